// File: doc/BRIEF.md
# Serial Channel Control Register and Enable Qualifier

This block holds the 8-bit control byte of one asynchronous serial channel and turns it into the signals that a separate transmit engine and receive engine need: a channel reset, a qualified enable for each direction, the frame configuration fields, and the line idle level to hold while the channel is powered down. Software updates the byte with a whole-byte write or with a set or clear of a single bit. The whole byte can always be read back.

Each direction has its own qualifier state machine. The state machine is stepped by `base_tick`, a one-cycle strobe that marks each base clock of the serial engines. Its states are Q_OFF (disabled), Q_ARM (one base tick seen since enable), Q_ON (qualified), Q_DR0 (enable just cleared, no tick yet) and Q_DR1 (enable cleared, one tick seen). These are the transitions:
- Q_OFF to Q_ARM on a tick while the enable bit is set.
- Q_ARM to Q_ON on a tick. Q_ARM returns to Q_OFF if the enable bit is cleared.
- Q_ON to Q_DR0 when the enable bit is cleared.
- Q_DR0 and Q_DR1 return to Q_ON if the enable bit is set again.
- Q_DR0 steps to Q_DR1 on a tick, and Q_DR1 steps to Q_OFF on a tick.

A clear of the power bit puts both machines in Q_OFF at once, through an asynchronous reset.

Top module: `uart_chan_ctl`

## Requirements
- R1: After `rst_n` is low, `rd_data` reads 0x10.
- R2: A byte write (`wr_en`=1, `wr_byte`=1) stores `wr_data`, and the write shows on `rd_data` from the next cycle. The fields map as follows: bit 7 is power, bit 6 is transmit enable, bit 5 is receive enable, bit 4 goes to `cfg_lsb_first`, bits 3:2 go to `cfg_parity`, bit 1 goes to `cfg_len8` and bit 0 goes to `cfg_stop2`.
- R3: A bit write (`wr_en`=1, `wr_byte`=0) sets bit `wr_bit_idx` to `wr_bit_val`. All other bits keep their values.
- R4: While the power bit is 0, `unit_rst_n` is 0 and `tx_en_q` and `rx_en_q` are 0. Both qualifiers return to Q_OFF without waiting for a clock.
- R5: `txd_hold` is 1 exactly while the power bit is 0. `txd_idle_level` is 1 when `idle_inv` is 0, and 0 when `idle_inv` is 1.
- R6: With power set, `tx_en_q` stays 0 after the first `base_tick` that follows the setting of transmit enable. It becomes 1 after the second such tick.
- R7: With power set, `rx_en_q` follows the same two-tick rule after receive enable is set.
- R8: When an enable bit is cleared, its qualified enable drops in the same cycle the bit reads 0. If the bit is set again before two ticks have passed, the qualified enable returns one clock later, with no tick needed. If the clear lasts two ticks, the full two-tick latency applies again.
- R9: `rx_start_ok` passes `rx_start_raw` only while `rx_en_q` is 1. A start bit that arrives before that is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, active low |
| base_tick | input | 1 | One-cycle strobe, once per base clock |
| wr_en | input | 1 | Register write strobe |
| wr_byte | input | 1 | 1: whole-byte write, 0: single-bit write |
| wr_data | input | 8 | Byte write data |
| wr_bit_idx | input | 3 | Bit index for a single-bit write |
| wr_bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 8 | Control byte readback |
| idle_inv | input | 1 | Inverts the powered-down line level |
| rx_start_raw | input | 1 | Start-bit detect from the receive front end |
| rx_start_ok | output | 1 | Start bit accepted |
| unit_rst_n | output | 1 | Reset to both engines, active low |
| tx_en_q | output | 1 | Qualified transmit enable |
| rx_en_q | output | 1 | Qualified receive enable |
| txd_hold | output | 1 | Transmit pin held at idle level |
| txd_idle_level | output | 1 | Level for the held transmit pin |
| cfg_lsb_first | output | 1 | Bit order field |
| cfg_parity | output | 2 | Parity select field |
| cfg_len8 | output | 1 | Character length field |
| cfg_stop2 | output | 1 | Stop-bit length field |

## Verification
The hardest case to reach is a short clear: the enable bit is cleared and set again between two base ticks, so the unit must resume without a re-initialization. The bench drives `base_tick` as a separate pulse, so it decides exactly how many ticks fall inside a clear window. It then compares a clear of one tick with a clear of two ticks. The same tick control places a start bit in Q_ARM, before the receiver is qualified.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int CTL_W    = 8;
    localparam int IDX_W    = $clog2(CTL_W);
    localparam int N_UNITS  = 2;

    localparam int B_PWR    = 7;
    localparam int B_TXE    = 6;
    localparam int B_RXE    = 5;
    localparam int B_ORDER  = 4;
    localparam int B_PAR_HI = 3;
    localparam int B_PAR_LO = 2;
    localparam int B_LEN    = 1;
    localparam int B_STOP   = 0;

    typedef enum logic [2:0] {
        Q_OFF = 3'd0,
        Q_ARM = 3'd1,
        Q_ON  = 3'd2,
        Q_DR0 = 3'd3,
        Q_DR1 = 3'd4
    } qual_state_e;

endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
    import uart_ctl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RESET_VAL = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [IDX_W-1:0] wr_bit_idx,
    input  logic             wr_bit_val,
    output logic [CTL_W-1:0] ctl_q
);

    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (wr_byte) ctl_d = wr_data;
            else         ctl_d[wr_bit_idx] = wr_bit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RESET_VAL;
        else        ctl_q <= ctl_d;
    end

    generate
        for (genvar b = 0; b < CTL_W; b++) begin : g_bitchk
            AST_BIT_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_byte && wr_bit_idx != IDX_W'(b)) |=> $stable(ctl_q[b])); // R3
        end
    endgenerate

endmodule

// File: rtl/uart_en_qual.sv
module uart_en_qual
    import uart_ctl_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic en,
    output logic en_q
);

    qual_state_e state, state_nx;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= Q_OFF;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_OFF: if (en && tick) state_nx = Q_ARM;
            Q_ARM: begin
                if (!en)       state_nx = Q_OFF;
                else if (tick) state_nx = Q_ON;
            end
            Q_ON:  if (!en) state_nx = Q_DR0;
            Q_DR0: begin
                if (en)        state_nx = Q_ON;
                else if (tick) state_nx = Q_DR1;
            end
            Q_DR1: begin
                if (en)        state_nx = Q_ON;
                else if (tick) state_nx = Q_OFF;
            end
            default: state_nx = Q_OFF;
        endcase
    end

    always_comb begin
        en_q = (state == Q_ON) && en;
    end

    AST_OFF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!arst_n)
        (state == Q_OFF && !tick) |=> (state == Q_OFF)); // R6
    AST_ARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!arst_n)
        (state == Q_ARM && !tick) |=> (state != Q_ON)); // R7
    AST_SHORT_CLEAR_RESUMES: assert property (@(posedge clk) disable iff (!arst_n)
        ((state == Q_DR0 || state == Q_DR1) && en) |=> (state == Q_ON)); // R8
    AST_QUAL_DROPS_WITH_EN: assert property (@(posedge clk) disable iff (!arst_n)
        !en |-> !en_q); // R8

endmodule

// File: rtl/uart_chan_ctl.sv
module uart_chan_ctl
    import uart_ctl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RESET_VAL = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [IDX_W-1:0] wr_bit_idx,
    input  logic             wr_bit_val,
    output logic [CTL_W-1:0] rd_data,
    input  logic             idle_inv,
    input  logic             rx_start_raw,
    output logic             rx_start_ok,
    output logic             unit_rst_n,
    output logic             tx_en_q,
    output logic             rx_en_q,
    output logic             txd_hold,
    output logic             txd_idle_level,
    output logic             cfg_lsb_first,
    output logic [1:0]       cfg_parity,
    output logic             cfg_len8,
    output logic             cfg_stop2
);

    logic [CTL_W-1:0]   ctl;
    logic               pwr;
    logic [N_UNITS-1:0] unit_en;
    logic [N_UNITS-1:0] unit_en_q;

    uart_ctl_reg #(.RESET_VAL(RESET_VAL)) reg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .wr_data    (wr_data),
        .wr_bit_idx (wr_bit_idx),
        .wr_bit_val (wr_bit_val),
        .ctl_q      (ctl)
    );

    always_comb begin
        pwr        = ctl[B_PWR];
        unit_rst_n = rst_n & pwr;
        unit_en[0] = ctl[B_TXE];
        unit_en[1] = ctl[B_RXE];
    end

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            uart_en_qual qual_i (
                .clk    (clk),
                .arst_n (unit_rst_n),
                .tick   (base_tick),
                .en     (unit_en[u]),
                .en_q   (unit_en_q[u])
            );
        end
    endgenerate

    always_comb begin
        rd_data        = ctl;
        tx_en_q        = unit_en_q[0];
        rx_en_q        = unit_en_q[1];
        rx_start_ok    = rx_start_raw & unit_en_q[1];
        txd_hold       = ~pwr;
        txd_idle_level = ~idle_inv;
        cfg_lsb_first  = ctl[B_ORDER];
        cfg_parity     = ctl[B_PAR_HI:B_PAR_LO];
        cfg_len8       = ctl[B_LEN];
        cfg_stop2      = ctl[B_STOP];
    end

    AST_POWER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[B_PWR] |-> (!tx_en_q && !rx_en_q && !unit_rst_n)); // R4
    AST_START_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start_raw && !rx_en_q) |-> !rx_start_ok); // R9

endmodule

// File: tb/uart_chan_ctl_tb_top.sv
module uart_chan_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_byte = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_bit_idx = '0;
    logic       wr_bit_val = 1'b0;
    logic [7:0] rd_data;
    logic       idle_inv = 1'b0;
    logic       rx_start_raw = 1'b0;
    logic       rx_start_ok, unit_rst_n, tx_en_q, rx_en_q;
    logic       txd_hold, txd_idle_level, cfg_lsb_first, cfg_len8, cfg_stop2;
    logic [1:0] cfg_parity;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_chan_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
        .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val), .rd_data(rd_data),
        .idle_inv(idle_inv), .rx_start_raw(rx_start_raw), .rx_start_ok(rx_start_ok),
        .unit_rst_n(unit_rst_n), .tx_en_q(tx_en_q), .rx_en_q(rx_en_q),
        .txd_hold(txd_hold), .txd_idle_level(txd_idle_level),
        .cfg_lsb_first(cfg_lsb_first), .cfg_parity(cfg_parity),
        .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_b(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_byte = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_1(input logic [2:0] idx, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_byte = 1'b0; wr_bit_idx = idx; wr_bit_val = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        base_tick = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset value", rd_data, 8'h10);
        chk("R4 reset unit_rst_n", {7'd0, unit_rst_n}, 8'd0);
    endtask

    task automatic t_fields();
        wr_b(8'h0B);
        chk("R2 readback", rd_data, 8'h0B);
        chk("R2 fields", {2'b0, cfg_lsb_first, cfg_parity, cfg_len8, cfg_stop2, 1'b0}, {2'b0, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0});
        wr_b(8'h14);
        chk("R2 fields b", {4'd0, cfg_lsb_first, cfg_parity, cfg_stop2}, {4'd0, 1'b1, 2'b01, 1'b0});
        wr_1(3'd1, 1'b1);
        chk("R3 bit set", rd_data, 8'h16);
        wr_1(3'd4, 1'b0);
        chk("R3 bit clear", rd_data, 8'h06);
        wr_1(3'd0, 1'b0);
        chk("R3 clear of zero bit", rd_data, 8'h06);
    endtask

    task automatic t_idle();
        wr_b(8'h00);
        idle_inv = 1'b0;
        @(negedge clk);
        chk("R5 hold off-power", {7'd0, txd_hold}, 8'd1);
        chk("R5 idle high", {7'd0, txd_idle_level}, 8'd1);
        idle_inv = 1'b1;
        @(negedge clk);
        chk("R5 idle low inverted", {7'd0, txd_idle_level}, 8'd0);
        idle_inv = 1'b0;
        wr_b(8'h80);
        chk("R5 hold released", {7'd0, txd_hold}, 8'd0);
        chk("R4 unit_rst_n up", {7'd0, unit_rst_n}, 8'd1);
    endtask

    task automatic t_tx_latency();
        wr_1(3'd6, 1'b1);
        chk("R6 before tick", {7'd0, tx_en_q}, 8'd0);
        tick();
        chk("R6 after one tick", {7'd0, tx_en_q}, 8'd0);
        tick();
        chk("R6 after two ticks", {7'd0, tx_en_q}, 8'd1);
    endtask

    task automatic t_reinit();
        wr_1(3'd6, 1'b0);
        chk("R8 drop on clear", {7'd0, tx_en_q}, 8'd0);
        tick();
        wr_1(3'd6, 1'b1);
        chk("R8 short clear pending", {7'd0, tx_en_q}, 8'd0);
        @(negedge clk);
        chk("R8 short clear resumes", {7'd0, tx_en_q}, 8'd1);
        wr_1(3'd6, 1'b0);
        tick();
        tick();
        wr_1(3'd6, 1'b1);
        @(negedge clk);
        chk("R8 long clear re-init", {7'd0, tx_en_q}, 8'd0);
        tick();
        chk("R8 long clear one tick", {7'd0, tx_en_q}, 8'd0);
        tick();
        chk("R8 long clear two ticks", {7'd0, tx_en_q}, 8'd1);
    endtask

    task automatic t_rx_and_start();
        wr_1(3'd5, 1'b1);
        rx_start_raw = 1'b1;
        @(negedge clk);
        chk("R9 start dropped off", {7'd0, rx_start_ok}, 8'd0);
        tick();
        chk("R7 after one tick", {7'd0, rx_en_q}, 8'd0);
        chk("R9 start dropped armed", {7'd0, rx_start_ok}, 8'd0);
        tick();
        chk("R7 after two ticks", {7'd0, rx_en_q}, 8'd1);
        chk("R9 start accepted", {7'd0, rx_start_ok}, 8'd1);
        rx_start_raw = 1'b0;
    endtask

    task automatic t_power_off();
        wr_1(3'd7, 1'b0);
        chk("R4 tx off", {7'd0, tx_en_q}, 8'd0);
        chk("R4 rx off", {7'd0, rx_en_q}, 8'd0);
        chk("R4 unit_rst_n low", {7'd0, unit_rst_n}, 8'd0);
        wr_1(3'd7, 1'b1);
        @(negedge clk);
        chk("R4 state cleared tx", {7'd0, tx_en_q}, 8'd0);
        chk("R4 state cleared rx", {7'd0, rx_en_q}, 8'd0);
        tick();
        tick();
        chk("R7 rx after power cycle", {7'd0, rx_en_q}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_idle();
        t_tx_latency();
        t_reinit();
        t_rx_and_start();
        t_power_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule